// File: doc/BRIEF.md
# Hotspot-Driven ROM/RAM Bank Mapper

This block maps a 4K cartridge window of an 8-bit console into a larger ROM and a separate RAM. Software changes the mapping by writing one control byte to a single hotspot address outside the window. That byte holds three fields: a memory-type flag, a destination slot and a 5-bit bank index. The mapper keeps four ROM slot records and four RAM slot records. Each CPU access inside the window becomes a physical ROM or RAM address with one enable.

ROM slots are 1K wide and tile the window. RAM slots are 512 bytes wide and are read in the lower half of the window. Each RAM slot has a write alias 0x800 above its read address. A RAM mapping therefore hides only the 512 bytes of the ROM slot that it overlaps. The mapper never switches banks by itself. Software must place a bank with valid vectors in the last slot.

Top module: `cart_bank_mapper`

## Requirements
- R1: A CPU write with address bit 12 low and address bits 7:0 equal to 0x3F is a control write. Its data byte becomes the new mapping from the next clock edge. No other access changes the mapping, and that includes reads of the hotspot and writes inside the window.
- R2: A control byte with bit 7 = 0 sets ROM slot `d[6:5]` to bank `d[4:0]`. A read at window offset `o` (address bit 12 set, `o` = address bits 11:0) that no valid RAM slot claims raises `rom_rd` with `rom_addr` = {ROM bank of slot `o[11:10]`, `o[9:0]`}.
- R3: A control byte with bit 7 = 1 sets RAM slot `d[6:5]` to bank `d[4:0]` and marks that slot valid. A read at an offset with `o[11]` = 0 whose RAM slot `o[10:9]` is valid raises `ram_rd` instead of `rom_rd`, with `ram_addr` = {RAM bank, `o[8:0]`}.
- R4: A write at an offset with `o[11]` = 1 whose RAM slot `o[10:9]` is valid raises `ram_wr`, with `ram_addr` = {that slot's RAM bank, `o[8:0]`}.
- R5: A valid RAM slot hides only its own 512 bytes. The other half of the 1K ROM slot keeps reading ROM.
- R6: A ROM control write to slot 0 clears the RAM valid flags of slots 0 and 1. A ROM control write to slot 1 clears those of slots 2 and 3. A ROM control write to slot 2 or 3 leaves the RAM flags unchanged.
- R7: After reset all RAM slots are invalid and every ROM slot selects bank 0.
- R8: At most one of `rom_rd`, `ram_rd`, `ram_wr` is high. All three stay low without a strobe, outside the window, and for a write that misses a valid RAM write alias.
- R9: Slots are independent. Mapping four consecutive RAM banks into the four RAM slots gives 2K of contiguous RAM at offsets 0x000 to 0x7FF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 13 | CPU address; bit 12 selects the cartridge window |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write data (control byte on hotspot writes) |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | 15 | Physical ROM address {bank, 10-bit offset} |
| ram_rd | output | 1 | RAM read enable |
| ram_wr | output | 1 | RAM write enable |
| ram_addr | output | 14 | Physical RAM address {bank, 9-bit offset} |

## Verification
The translated enables and addresses follow the CPU inputs in the same cycle with no register between them. The bench samples them 3 ns after it drives a new access, inside that same cycle. A control write changes the slot registers at the next rising edge, so its effect is due on the very next access. The bench's reference model therefore updates only after it has queued the expectation for the control write's own cycle. Each queued item is compared against the outputs of the cycle it was pushed for, and the comparison reports which requirement that access exercises.

// File: rtl/cart_bank_mapper_pkg.sv
// Shared constants and types for the bank mapper.
// Assumes the control byte layout: type flag on top, slot in the next
// two bits, bank index in the low five bits.
package cart_bank_mapper_pkg;
    localparam int SLOT_CNT = 4;
    localparam int SLOT_W   = $clog2(SLOT_CNT);
    localparam int BANK_W   = 5;
    localparam int ROM_OFS_W = 10;
    localparam int RAM_OFS_W = 9;

    typedef struct packed {
        logic              is_ram;
        logic [SLOT_W-1:0] slot;
        logic [BANK_W-1:0] bank;
    } ctrl_word_t;

    typedef logic [SLOT_CNT-1:0][BANK_W-1:0] bank_vec_t;
endpackage

// File: rtl/cart_bank_mapper_hotspot.sv
// Detects control writes to the hotspot and splits the control byte.
// Assumes the hotspot lies outside the cartridge window (top address bit low)
// and is matched on the low eight address bits only.
module cart_bank_mapper_hotspot
    import cart_bank_mapper_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [7:0] HOTSPOT = 8'h3F
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_wr,
    input  logic [7:0]        cpu_wdata,
    output logic              upd_rom,
    output logic              upd_ram,
    output logic [SLOT_W-1:0] upd_slot,
    output logic [BANK_W-1:0] upd_bank
);
    ctrl_word_t word;
    logic       hit;

    // Decode a control write and its fields.
    always_comb begin
        word     = ctrl_word_t'(cpu_wdata);
        hit      = cpu_wr && !cpu_addr[ADDR_W-1] && (cpu_addr[7:0] == HOTSPOT);
        upd_rom  = hit && !word.is_ram;
        upd_ram  = hit &&  word.is_ram;
        upd_slot = word.slot;
        upd_bank = word.bank;
    end
endmodule

// File: rtl/cart_bank_mapper_regs.sv
// Holds four ROM slot banks, four RAM slot banks and the RAM valid flags.
// A ROM update of slot k clears the RAM slots that read inside ROM slot k.
module cart_bank_mapper_regs
    import cart_bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_rom,
    input  logic              upd_ram,
    input  logic [SLOT_W-1:0] upd_slot,
    input  logic [BANK_W-1:0] upd_bank,
    output bank_vec_t         rom_bank,
    output bank_vec_t         ram_bank,
    output logic [SLOT_CNT-1:0] ram_valid
);
    // RAM slots are half the ROM slot size, so RAM slot g sits in ROM slot g/2.
    localparam int RAM_PER_ROM = 2;

    for (genvar g = 0; g < SLOT_CNT; g++) begin : g_slot
        localparam int OVER_ROM = g / RAM_PER_ROM;

        // ROM slot bank register, bank 0 after reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rom_bank[g] <= '0;
            else if (upd_rom && (upd_slot == SLOT_W'(g)))
                rom_bank[g] <= upd_bank;
        end

        // RAM slot bank and valid flag; ROM remap of the covering slot clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ram_bank[g]  <= '0;
                ram_valid[g] <= 1'b0;
            end else if (upd_ram && (upd_slot == SLOT_W'(g))) begin
                ram_bank[g]  <= upd_bank;
                ram_valid[g] <= 1'b1;
            end else if (upd_rom && (upd_slot == SLOT_W'(OVER_ROM))) begin
                ram_valid[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cart_bank_mapper_xlate.sv
// Turns a CPU access in the cartridge window into a physical ROM or RAM access.
// Assumes read and write strobes are not raised together; a write wins if so.
module cart_bank_mapper_xlate
    import cart_bank_mapper_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic                      cpu_rd,
    input  logic                      cpu_wr,
    input  bank_vec_t                 rom_bank,
    input  bank_vec_t                 ram_bank,
    input  logic [SLOT_CNT-1:0]       ram_valid,
    output logic                      rom_rd,
    output logic [BANK_W+ROM_OFS_W-1:0] rom_addr,
    output logic                      ram_rd,
    output logic                      ram_wr,
    output logic [BANK_W+RAM_OFS_W-1:0] ram_addr
);
    localparam int OFS_W = ADDR_W - 1;

    logic             in_win;
    logic [OFS_W-1:0] ofs;
    logic             wr_half;
    logic [SLOT_W-1:0] rom_slot;
    logic [SLOT_W-1:0] ram_slot;
    logic             ram_hit;

    // Split the window offset into slot selects.
    always_comb begin
        in_win   = cpu_addr[ADDR_W-1];
        ofs      = cpu_addr[OFS_W-1:0];
        wr_half  = ofs[OFS_W-1];
        rom_slot = ofs[ROM_OFS_W +: SLOT_W];
        ram_slot = ofs[RAM_OFS_W +: SLOT_W];
        ram_hit  = in_win && ram_valid[ram_slot];
    end

    // Select the enable: RAM read beats ROM, writes only reach valid RAM aliases.
    always_comb begin
        rom_rd = 1'b0;
        ram_rd = 1'b0;
        ram_wr = 1'b0;
        if (cpu_wr) begin
            ram_wr = ram_hit && wr_half;
        end else if (cpu_rd && in_win) begin
            if (ram_hit && !wr_half) ram_rd = 1'b1;
            else                     rom_rd = 1'b1;
        end
    end

    // Form the physical addresses from the selected slot banks.
    always_comb begin
        rom_addr = {rom_bank[rom_slot], ofs[ROM_OFS_W-1:0]};
        ram_addr = {ram_bank[ram_slot], ofs[RAM_OFS_W-1:0]};
    end
endmodule

// File: rtl/cart_bank_mapper.sv
// Cartridge bank mapper top: hotspot decode, slot registers, address translation.
// Assumes a 13-bit CPU address with the 4K window at bit 12 set.
module cart_bank_mapper
    import cart_bank_mapper_pkg::*;
#(
    parameter int         ADDR_W  = 13,
    parameter logic [7:0] HOTSPOT = 8'h3F
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cpu_addr,
    input  logic                        cpu_rd,
    input  logic                        cpu_wr,
    input  logic [7:0]                  cpu_wdata,
    output logic                        rom_rd,
    output logic [BANK_W+ROM_OFS_W-1:0] rom_addr,
    output logic                        ram_rd,
    output logic                        ram_wr,
    output logic [BANK_W+RAM_OFS_W-1:0] ram_addr
);
    logic                upd_rom;
    logic                upd_ram;
    logic [SLOT_W-1:0]   upd_slot;
    logic [BANK_W-1:0]   upd_bank;
    bank_vec_t           rom_bank;
    bank_vec_t           ram_bank;
    logic [SLOT_CNT-1:0] ram_valid;

    cart_bank_mapper_hotspot #(.ADDR_W(ADDR_W), .HOTSPOT(HOTSPOT)) u_hot (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .cpu_wdata(cpu_wdata),
        .upd_rom  (upd_rom),
        .upd_ram  (upd_ram),
        .upd_slot (upd_slot),
        .upd_bank (upd_bank)
    );

    cart_bank_mapper_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_rom  (upd_rom),
        .upd_ram  (upd_ram),
        .upd_slot (upd_slot),
        .upd_bank (upd_bank),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_valid(ram_valid)
    );

    cart_bank_mapper_xlate #(.ADDR_W(ADDR_W)) u_xlate (
        .cpu_addr (cpu_addr),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .rom_bank (rom_bank),
        .ram_bank (ram_bank),
        .ram_valid(ram_valid),
        .rom_rd   (rom_rd),
        .rom_addr (rom_addr),
        .ram_rd   (ram_rd),
        .ram_wr   (ram_wr),
        .ram_addr (ram_addr)
    );
endmodule

// File: rtl/cart_bank_mapper_chk.sv
// Port-level checker for the bank mapper, bound to every instance of the top.
module cart_bank_mapper_chk
    import cart_bank_mapper_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [ADDR_W-1:0]           cpu_addr,
    input logic                        cpu_rd,
    input logic                        cpu_wr,
    input logic                        rom_rd,
    input logic [BANK_W+ROM_OFS_W-1:0] rom_addr,
    input logic                        ram_rd,
    input logic                        ram_wr,
    input logic [BANK_W+RAM_OFS_W-1:0] ram_addr
);
    // R8: the enables never overlap.
    a_r8_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rom_rd, ram_rd, ram_wr}));

    // R8: without a strobe nothing is enabled.
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> !(rom_rd || ram_rd || ram_wr));

    // R2: ROM reads keep the low ten offset bits.
    a_r2_rom_offset: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd |-> (cpu_rd && cpu_addr[ADDR_W-1] && rom_addr[ROM_OFS_W-1:0] == cpu_addr[ROM_OFS_W-1:0]));

    // R3: RAM reads only come from the lower half of the window.
    a_r3_ram_read_half: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> (cpu_addr[ADDR_W-1] && !cpu_addr[ADDR_W-2] && ram_addr[RAM_OFS_W-1:0] == cpu_addr[RAM_OFS_W-1:0]));

    // R4: RAM writes only come from the upper half of the window.
    a_r4_ram_write_half: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (cpu_wr && cpu_addr[ADDR_W-1] && cpu_addr[ADDR_W-2]));

    // R1: with no write in between, a repeated read maps the same way.
    a_r1_map_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && $past(cpu_rd) && !$past(cpu_wr) && $stable(cpu_addr))
        |-> $stable({rom_rd, ram_rd, rom_addr, ram_addr}));
endmodule

bind cart_bank_mapper cart_bank_mapper_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cpu_addr(cpu_addr),
    .cpu_rd  (cpu_rd),
    .cpu_wr  (cpu_wr),
    .rom_rd  (rom_rd),
    .rom_addr(rom_addr),
    .ram_rd  (ram_rd),
    .ram_wr  (ram_wr),
    .ram_addr(ram_addr)
);

// File: tb/cart_bank_mapper_tb.sv
module cart_bank_mapper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic        rom_rd;
    logic [14:0] rom_addr;
    logic        ram_rd;
    logic        ram_wr;
    logic [13:0] ram_addr;

    cart_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .rom_rd(rom_rd),
        .rom_addr(rom_addr), .ram_rd(ram_rd), .ram_wr(ram_wr), .ram_addr(ram_addr)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic        e_rom_rd;
        logic        e_ram_rd;
        logic        e_ram_wr;
        logic [14:0] e_rom_addr;
        logic [13:0] e_ram_addr;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    event go;

    // Reference model of the slot state
    logic [4:0] m_rom[4];
    logic [4:0] m_ram[4];
    logic       m_val[4];

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin
            m_rom[i] = '0; m_ram[i] = '0; m_val[i] = 1'b0;
        end
    endtask

    // Drive one access, push what the outputs must show in this cycle.
    task automatic access(input logic [12:0] a, input bit rd, input bit wr,
                          input logic [7:0] d, input string tag);
        exp_t e;
        logic [1:0] rs;
        @(posedge clk);
        #1;
        cpu_addr = a; cpu_rd = rd; cpu_wr = wr; cpu_wdata = d;
        rs = a[10:9];
        e.e_rom_rd = 1'b0; e.e_ram_rd = 1'b0; e.e_ram_wr = 1'b0;
        e.e_rom_addr = {m_rom[a[11:10]], a[9:0]};
        e.e_ram_addr = {m_ram[rs], a[8:0]};
        e.tag = tag;
        if (wr) e.e_ram_wr = a[12] && a[11] && m_val[rs];
        else if (rd && a[12]) begin
            if (!a[11] && m_val[rs]) e.e_ram_rd = 1'b1;
            else e.e_rom_rd = 1'b1;
        end
        q.push_back(e);
        -> go;
        if (wr && !a[12] && a[7:0] == 8'h3F) begin
            if (d[7]) begin
                m_ram[d[6:5]] = d[4:0]; m_val[d[6:5]] = 1'b1;
            end else begin
                m_rom[d[6:5]] = d[4:0];
                if (d[6:5] < 2) begin
                    m_val[2*d[6:5]] = 1'b0; m_val[2*d[6:5]+1] = 1'b0;
                end
            end
        end
    endtask

    task automatic rd(input logic [12:0] a, input string tag);
        access(a, 1'b1, 1'b0, 8'h00, tag);
    endtask
    task automatic wr(input logic [12:0] a, input logic [7:0] d, input string tag);
        access(a, 1'b0, 1'b1, d, tag);
    endtask
    task automatic ctl(input logic [7:0] d, input string tag);
        access(13'h003F, 1'b0, 1'b1, d, tag);
    endtask

    // Monitor: compare each queued item in the cycle it was pushed for.
    initial begin
        forever begin
            exp_t e;
            @(go);
            #3;
            e = q.pop_front();
            n_vec++;
            if (rom_rd !== e.e_rom_rd || ram_rd !== e.e_ram_rd || ram_wr !== e.e_ram_wr ||
                (e.e_rom_rd && rom_addr !== e.e_rom_addr) ||
                ((e.e_ram_rd || e.e_ram_wr) && ram_addr !== e.e_ram_addr)) begin
                n_bad++;
                $display("FAIL %s: got rd/rr/rw=%b%b%b rom=%h ram=%h exp %b%b%b rom=%h ram=%h",
                         e.tag, rom_rd, ram_rd, ram_wr, rom_addr, ram_addr,
                         e.e_rom_rd, e.e_ram_rd, e.e_ram_wr, e.e_rom_addr, e.e_ram_addr);
            end
        end
    end

    // Watchdog
    initial begin
        #1ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R7: reset state, all ROM slots bank 0, RAM invalid
        rd(13'h1000, "R7");
        rd(13'h1605, "R7");
        rd(13'h1BFF, "R7");
        rd(13'h1FFC, "R7");
        // R8: write in window without RAM, idle, outside window
        wr(13'h1810, 8'hAA, "R8");
        access(13'h1234, 1'b0, 1'b0, 8'h00, "R8");
        rd(13'h0080, "R8");
        // R2: ROM mapping
        ctl({1'b0, 2'd3, 5'd17}, "R2");
        rd(13'h1FFC, "R2");
        ctl({1'b0, 2'd0, 5'd5}, "R2");
        ctl({1'b0, 2'd1, 5'd31}, "R2");
        ctl({1'b0, 2'd2, 5'd1}, "R2");
        rd(13'h1001, "R2");
        rd(13'h17FF, "R2");
        rd(13'h1A00, "R2");
        // R1: non-hotspot writes and hotspot reads do not remap
        wr(13'h007F, 8'h1F, "R1");
        wr(13'h103F, 8'h00, "R1");
        rd(13'h003F, "R1");
        rd(13'h1001, "R1");
        rd(13'h1C00, "R1");
        // R3 / R5: RAM slot 1 bank 9
        ctl({1'b1, 2'd1, 5'd9}, "R3");
        rd(13'h1210, "R3");
        rd(13'h1100, "R5");
        rd(13'h1A10, "R5");
        // R4: write alias of slot 1
        wr(13'h1A10, 8'h55, "R4");
        wr(13'h1810, 8'h55, "R8");
        wr(13'h1210, 8'h55, "R8");
        // R9: contiguous 2K
        ctl({1'b1, 2'd0, 5'd4}, "R9");
        ctl({1'b1, 2'd1, 5'd5}, "R9");
        ctl({1'b1, 2'd2, 5'd6}, "R9");
        ctl({1'b1, 2'd3, 5'd7}, "R9");
        rd(13'h11FF, "R9");
        rd(13'h1200, "R9");
        rd(13'h17FF, "R9");
        wr(13'h1E00, 8'h01, "R9");
        rd(13'h1C00, "R9");
        // R6: ROM remap slot 1 clears RAM slots 2,3 only
        ctl({1'b0, 2'd1, 5'd2}, "R6");
        rd(13'h1400, "R6");
        rd(13'h1600, "R6");
        wr(13'h1C00, 8'h01, "R6");
        rd(13'h1000, "R6");
        ctl({1'b0, 2'd3, 5'd8}, "R6");
        rd(13'h1200, "R6");
        wr(13'h1A01, 8'h01, "R6");
        ctl({1'b0, 2'd0, 5'd3}, "R6");
        rd(13'h1000, "R6");
        rd(13'h1200, "R6");
        @(posedge clk);
        #5;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule